// File: doc/BRIEF.md
# Flash Page Program-Verify Controller

This block drives the complete programming loop for one page of on-chip flash. Software, or a host engine, first fills a page-sized staging buffer through a simple byte-load port and then pulses `start` with the page number. The controller raises the software-enable line and waits a settling time. It then repeats passes until the page is good or the pass budget runs out. In each pass it streams the whole page of reprogram data into the flash write latches, asks an external pulse sequencer for a program pulse and enters verify mode. It then reads the page back in 16-bit words and rebuilds its per-bit masks from what it reads.

Two internal buffers track the progress. The reprogram buffer holds a 0 only for bits that are meant to be 0 and still read 1. The additional buffer holds a 0 only for bits that were pulsed in this pass and now read 0. During the early passes these bits get a second, longer pulse so that they are firmly programmed. The pulse width code changes from short to long once the early passes are over. All analog waits are cycle-count parameters. The pulse durations belong to the sequencer, which only receives a width code.

Top module: `flash_page_prog`

## Requirements
- R1: While idle, `start` latches `pageSel`, sets `busy` and `sweOn`, and holds off the first flash write for at least WAIT_SWE cycles. `busy` stays high up to and including the cycle of `done` or `fail` and is low on the next cycle. A `start` pulse while busy has no effect. While idle, no write, read or pulse request is issued.
- R2: Each pass writes all PAGE_BYTES bytes in ascending order, byte index 0 first, at address {latched page, index}, so the low address bits of the first byte are zero. Bytes not loaded since the last operation read as 0xFF, because the staging buffer resets to 0xFF and is refilled with 0xFF when each operation ends.
- R3: A single-cycle `pulseGo` follows each write burst, with `sweOn` high and `pvOn` low. `pulseSel` is 0 (short) for passes 1 to EARLY_LAST, 1 (long) for later passes and 2 for the additional pulse.
- R4: Verification runs with `pvOn` high. For each even byte address of the page, the block issues a dummy write of 0xFF to that address, waits WAIT_EPS cycles, then raises `vrReq` until `vrValid`. `vrData[15:8]` belongs to the even byte and `vrData[7:0]` to the odd byte.
- R5: From the verify data V and the staged data D, the reprogram byte becomes D | ~V. This byte is what the next pass writes.
- R6: In passes 1 to EARLY_LAST only, after `pvOn` drops and WAIT_ETA elapses, the block writes the additional bytes X' | V (X' being the bytes pulsed in this pass) and requests a pulse with `pulseSel` = 2. Later passes skip this step.
- R7: A pass in which every byte verifies and no additional byte holds a 0 ends the operation. `sweOn` drops, and after WAIT_THETA `done` pulses for one cycle. At that point the flash holds the staged data.
- R8: After any other pass the pass counter, which starts at 1, is incremented. When it reaches ITER_LIMIT, `sweOn` drops and after WAIT_THETA `fail` pulses for one cycle. `done` and `fail` are never high together.
- R9: Byte loads (`ldEn`) are ignored while busy and do not alter the data used for verification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ldEn | input | 1 | Load one byte into the staging buffer |
| ldIdx | input | IDX_W | Byte index within the page |
| ldData | input | 8 | Byte to stage |
| start | input | 1 | Begin programming the page |
| pageSel | input | PAGE_W | Page number to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success strobe |
| fail | output | 1 | One-cycle failure strobe |
| sweOn | output | 1 | Flash software-enable level |
| pvOn | output | 1 | Flash program-verify mode level |
| flWe | output | 1 | Flash latch byte write strobe |
| flAddr | output | ADDR_W | Flash byte address |
| flData | output | 8 | Flash write byte |
| vrReq | output | 1 | Verify read request, held until `vrValid` |
| vrAddr | output | ADDR_W | Even byte address of the verify word |
| vrData | input | 16 | Verify word, even byte in the upper half |
| vrValid | input | 1 | Verify word valid |
| pulseGo | output | 1 | One-cycle program pulse request |
| pulseSel | output | 2 | Pulse width code: 0 short, 1 long, 2 additional |
| pulseDone | input | 1 | Pulse sequencer finished |

## Verification
The hardest situations to reach are the pass where early behaviour stops and the pass budget running out. Both depend on how many pulses individual bits need, which the ports cannot set directly. The bench therefore models the flash array: each bit has its own count of pulses before it reads 0. Choosing those counts per scenario places the last bit to program exactly at pass EARLY_LAST, past it, or beyond the limit. At every pulse the model compares the whole latched page with masks it computes itself from the staged data and the cell state.

// File: rtl/fpv_pkg.sv
package fpv_pkg;

  typedef enum logic [1:0] {
    PW_SHORT = 2'd0,
    PW_LONG  = 2'd1,
    PW_EXTRA = 2'd2
  } pulseW_t;

  typedef enum logic [2:0] {
    TM_SWE,
    TM_GAMMA,
    TM_EPS,
    TM_ETA,
    TM_THETA
  } tmSel_t;

  typedef enum logic [3:0] {
    S_IDLE, S_SWE, S_WREP, S_PREQ, S_PWAIT, S_PVON, S_DUMMY, S_EPS,
    S_READ, S_PVOFF, S_WADD, S_AREQ, S_AWAIT, S_NEXT, S_EVAL, S_END
  } state_t;

  typedef struct packed {
    logic   pageLatch;
    logic   bufInit;
    logic   bufClear;
    logic   idxClr;
    logic   idxStep1;
    logic   idxStep2;
    logic   tmLoad;
    tmSel_t tmSel;
    logic   tmDec;
    logic   verCap;
    logic   passClr;
    logic   iterInit;
    logic   iterInc;
  } dpCtl_t;

endpackage

// File: rtl/fpv_datapath.sv
module fpv_datapath
  import fpv_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int PAGE_W     = 9,
  parameter int ITER_LIMIT = 1000,
  parameter int EARLY_LAST = 6,
  parameter int TM_W       = 16,
  parameter int WAIT_SWE   = 100,
  parameter int WAIT_GAMMA = 20,
  parameter int WAIT_EPS   = 10,
  parameter int WAIT_ETA   = 20,
  parameter int WAIT_THETA = 100,
  localparam int IDX_W  = $clog2(PAGE_BYTES),
  localparam int ADDR_W = PAGE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              loadOk,
  input  logic              ldEn,
  input  logic [IDX_W-1:0]  ldIdx,
  input  logic [7:0]        ldData,
  input  logic [PAGE_W-1:0] pageSel,
  input  logic              wrAdd,
  input  logic              dummyWr,
  input  logic [15:0]       vrData,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flData,
  output logic [ADDR_W-1:0] vrAddr,
  output logic              idxLastByte,
  output logic              idxLastWord,
  output logic              tmZero,
  output logic              earlyPass,
  output logic              pageOk,
  output logic              iterMaxed
);

  localparam int ITER_W = $clog2(ITER_LIMIT + 1);

  logic [7:0]        progBuf [PAGE_BYTES];
  logic [7:0]        reprBuf [PAGE_BYTES];
  logic [7:0]        addBuf  [PAGE_BYTES];
  logic [IDX_W-1:0]  idx;
  logic [PAGE_W-1:0] pageReg;
  logic [TM_W-1:0]   tm;
  logic [ITER_W-1:0] iter;
  logic              allOk;
  logic              mPend;

  logic [IDX_W-1:0]  idxE, idxO;
  logic [7:0]        vEven, vOdd;
  logic [7:0]        newXe, newXo, newYe, newYo;

  assign idxE  = {idx[IDX_W-1:1], 1'b0};
  assign idxO  = {idx[IDX_W-1:1], 1'b1};
  assign vEven = vrData[15:8];
  assign vOdd  = vrData[7:0];

  // reprogram mask: staged data OR not verified
  assign newXe = progBuf[idxE] | ~vEven;
  assign newXo = progBuf[idxO] | ~vOdd;
  // additional mask: pulsed mask OR verified
  assign newYe = reprBuf[idxE] | vEven;
  assign newYo = reprBuf[idxO] | vOdd;

  // staging buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progBuf <= '{default: 8'hFF};
    end else if (ctl.bufClear) begin
      progBuf <= '{default: 8'hFF};
    end else if (ldEn && loadOk) begin
      progBuf[ldIdx] <= ldData;
    end
  end

  // reprogram buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reprBuf <= '{default: 8'hFF};
    end else if (ctl.bufClear) begin
      reprBuf <= '{default: 8'hFF};
    end else if (ctl.bufInit) begin
      reprBuf <= progBuf;
    end else if (ctl.verCap) begin
      reprBuf[idxE] <= newXe;
      reprBuf[idxO] <= newXo;
    end
  end

  // additional-program buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addBuf <= '{default: 8'hFF};
    end else if (ctl.bufClear || ctl.bufInit) begin
      addBuf <= '{default: 8'hFF};
    end else if (ctl.verCap) begin
      addBuf[idxE] <= earlyPass ? newYe : 8'hFF;
      addBuf[idxO] <= earlyPass ? newYo : 8'hFF;
    end
  end

  // byte / word index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             idx <= '0;
    else if (ctl.idxClr)   idx <= '0;
    else if (ctl.idxStep1) idx <= idx + IDX_W'(1);
    else if (ctl.idxStep2) idx <= idx + IDX_W'(2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pageReg <= '0;
    else if (ctl.pageLatch) pageReg <= pageSel;
  end

  // settle timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tm <= '0;
    end else if (ctl.tmLoad) begin
      unique case (ctl.tmSel)
        TM_SWE:   tm <= TM_W'(WAIT_SWE);
        TM_GAMMA: tm <= TM_W'(WAIT_GAMMA);
        TM_EPS:   tm <= TM_W'(WAIT_EPS);
        TM_ETA:   tm <= TM_W'(WAIT_ETA);
        default:  tm <= TM_W'(WAIT_THETA);
      endcase
    end else if (ctl.tmDec && tm != '0) begin
      tm <= tm - TM_W'(1);
    end
  end

  // pass counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             iter <= '0;
    else if (ctl.iterInit) iter <= ITER_W'(1);
    else if (ctl.iterInc)  iter <= iter + ITER_W'(1);
  end

  // pass result flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      allOk <= 1'b1;
      mPend <= 1'b0;
    end else if (ctl.passClr) begin
      allOk <= 1'b1;
      mPend <= 1'b0;
    end else if (ctl.verCap) begin
      if (newXe != 8'hFF || newXo != 8'hFF) allOk <= 1'b0;
      if (earlyPass && (newYe != 8'hFF || newYo != 8'hFF)) mPend <= 1'b1;
    end
  end

  assign flAddr      = {pageReg, idx};
  assign vrAddr      = {pageReg, idxE};
  assign flData      = dummyWr ? 8'hFF : (wrAdd ? addBuf[idx] : reprBuf[idx]);
  assign idxLastByte = (idx == IDX_W'(PAGE_BYTES - 1));
  assign idxLastWord = (idx == IDX_W'(PAGE_BYTES - 2));
  assign tmZero      = (tm == '0);
  assign earlyPass   = (iter <= ITER_W'(EARLY_LAST));
  assign pageOk      = allOk && !mPend;
  assign iterMaxed   = (iter >= ITER_W'(ITER_LIMIT));

endmodule

// File: rtl/fpv_ctrl.sv
module fpv_ctrl
  import fpv_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    pulseDone,
  input  logic    vrValid,
  input  logic    idxLastByte,
  input  logic    idxLastWord,
  input  logic    tmZero,
  input  logic    earlyPass,
  input  logic    pageOk,
  input  logic    iterMaxed,
  output dpCtl_t  ctl,
  output logic    loadOk,
  output logic    busy,
  output logic    done,
  output logic    fail,
  output logic    sweOn,
  output logic    pvOn,
  output logic    flWe,
  output logic    wrAdd,
  output logic    dummyWr,
  output logic    vrReq,
  output logic    pulseGo,
  output pulseW_t pulseSel
);

  state_t state, nextState;
  logic   okReg, okNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      okReg <= 1'b0;
    end else begin
      state <= nextState;
      okReg <= okNext;
    end
  end

  always_comb begin
    nextState = state;
    okNext    = okReg;
    ctl       = '0;
    done      = 1'b0;
    fail      = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.pageLatch = 1'b1;
        ctl.bufInit   = 1'b1;
        ctl.iterInit  = 1'b1;
        ctl.passClr   = 1'b1;
        ctl.tmLoad    = 1'b1;
        ctl.tmSel     = TM_SWE;
        nextState     = S_SWE;
      end
      S_SWE: begin
        ctl.tmDec = 1'b1;
        if (tmZero) begin
          ctl.idxClr = 1'b1;
          nextState  = S_WREP;
        end
      end
      S_WREP: begin
        ctl.idxStep1 = 1'b1;
        if (idxLastByte) nextState = S_PREQ;
      end
      S_PREQ: nextState = S_PWAIT;
      S_PWAIT: if (pulseDone) begin
        ctl.tmLoad = 1'b1;
        ctl.tmSel  = TM_GAMMA;
        nextState  = S_PVON;
      end
      S_PVON: begin
        ctl.tmDec = 1'b1;
        if (tmZero) begin
          ctl.idxClr = 1'b1;
          nextState  = S_DUMMY;
        end
      end
      S_DUMMY: begin
        ctl.tmLoad = 1'b1;
        ctl.tmSel  = TM_EPS;
        nextState  = S_EPS;
      end
      S_EPS: begin
        ctl.tmDec = 1'b1;
        if (tmZero) nextState = S_READ;
      end
      S_READ: if (vrValid) begin
        ctl.verCap   = 1'b1;
        ctl.idxStep2 = 1'b1;
        if (idxLastWord) begin
          ctl.tmLoad = 1'b1;
          ctl.tmSel  = TM_ETA;
          nextState  = S_PVOFF;
        end else begin
          nextState = S_DUMMY;
        end
      end
      S_PVOFF: begin
        ctl.tmDec = 1'b1;
        if (tmZero) begin
          if (earlyPass) begin
            ctl.idxClr = 1'b1;
            nextState  = S_WADD;
          end else begin
            nextState = S_NEXT;
          end
        end
      end
      S_WADD: begin
        ctl.idxStep1 = 1'b1;
        if (idxLastByte) nextState = S_AREQ;
      end
      S_AREQ: nextState = S_AWAIT;
      S_AWAIT: if (pulseDone) nextState = S_NEXT;
      S_NEXT: begin
        if (pageOk) begin
          okNext     = 1'b1;
          ctl.tmLoad = 1'b1;
          ctl.tmSel  = TM_THETA;
          nextState  = S_END;
        end else begin
          ctl.iterInc = 1'b1;
          nextState   = S_EVAL;
        end
      end
      S_EVAL: begin
        if (iterMaxed) begin
          okNext     = 1'b0;
          ctl.tmLoad = 1'b1;
          ctl.tmSel  = TM_THETA;
          nextState  = S_END;
        end else begin
          ctl.passClr = 1'b1;
          ctl.idxClr  = 1'b1;
          nextState   = S_WREP;
        end
      end
      S_END: begin
        ctl.tmDec = 1'b1;
        if (tmZero) begin
          ctl.bufClear = 1'b1;
          done         = okReg;
          fail         = !okReg;
          nextState    = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy     = (state != S_IDLE);
  assign loadOk   = (state == S_IDLE) && !start;
  assign sweOn    = (state != S_IDLE) && (state != S_END);
  assign pvOn     = (state == S_PVON) || (state == S_DUMMY) ||
                    (state == S_EPS)  || (state == S_READ);
  assign flWe     = (state == S_WREP) || (state == S_WADD) || (state == S_DUMMY);
  assign wrAdd    = (state == S_WADD);
  assign dummyWr  = (state == S_DUMMY);
  assign vrReq    = (state == S_READ);
  assign pulseGo  = (state == S_PREQ) || (state == S_AREQ);
  assign pulseSel = (state == S_AREQ) ? PW_EXTRA : (earlyPass ? PW_SHORT : PW_LONG);

endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
  import fpv_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int PAGE_W     = 9,
  parameter int ITER_LIMIT = 1000,
  parameter int EARLY_LAST = 6,
  parameter int TM_W       = 16,
  parameter int WAIT_SWE   = 100,
  parameter int WAIT_GAMMA = 20,
  parameter int WAIT_EPS   = 10,
  parameter int WAIT_ETA   = 20,
  parameter int WAIT_THETA = 100,
  localparam int IDX_W  = $clog2(PAGE_BYTES),
  localparam int ADDR_W = PAGE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldEn,
  input  logic [IDX_W-1:0]  ldIdx,
  input  logic [7:0]        ldData,
  input  logic              start,
  input  logic [PAGE_W-1:0] pageSel,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              sweOn,
  output logic              pvOn,
  output logic              flWe,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flData,
  output logic              vrReq,
  output logic [ADDR_W-1:0] vrAddr,
  input  logic [15:0]       vrData,
  input  logic              vrValid,
  output logic              pulseGo,
  output logic [1:0]        pulseSel,
  input  logic              pulseDone
);

  dpCtl_t  ctl;
  pulseW_t pulseKind;
  logic    loadOk, wrAdd, dummyWr;
  logic    idxLastByte, idxLastWord, tmZero, earlyPass, pageOk, iterMaxed;

  fpv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .pulseDone(pulseDone), .vrValid(vrValid),
    .idxLastByte(idxLastByte), .idxLastWord(idxLastWord), .tmZero(tmZero),
    .earlyPass(earlyPass), .pageOk(pageOk), .iterMaxed(iterMaxed),
    .ctl(ctl), .loadOk(loadOk), .busy(busy), .done(done), .fail(fail),
    .sweOn(sweOn), .pvOn(pvOn), .flWe(flWe), .wrAdd(wrAdd), .dummyWr(dummyWr),
    .vrReq(vrReq), .pulseGo(pulseGo), .pulseSel(pulseKind)
  );

  fpv_datapath #(
    .PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W), .ITER_LIMIT(ITER_LIMIT),
    .EARLY_LAST(EARLY_LAST), .TM_W(TM_W), .WAIT_SWE(WAIT_SWE),
    .WAIT_GAMMA(WAIT_GAMMA), .WAIT_EPS(WAIT_EPS), .WAIT_ETA(WAIT_ETA),
    .WAIT_THETA(WAIT_THETA)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .loadOk(loadOk), .ldEn(ldEn),
    .ldIdx(ldIdx), .ldData(ldData), .pageSel(pageSel), .wrAdd(wrAdd),
    .dummyWr(dummyWr), .vrData(vrData), .flAddr(flAddr), .flData(flData),
    .vrAddr(vrAddr), .idxLastByte(idxLastByte), .idxLastWord(idxLastWord),
    .tmZero(tmZero), .earlyPass(earlyPass), .pageOk(pageOk), .iterMaxed(iterMaxed)
  );

  assign pulseSel = pulseKind;

endmodule

// File: rtl/fpv_checker.sv
module fpv_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              sweOn,
  input logic              pvOn,
  input logic              flWe,
  input logic [7:0]        flData,
  input logic              vrReq,
  input logic [ADDR_W-1:0] vrAddr,
  input logic              pulseGo
);

  // R8
  end_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(done && fail));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);

  // R8
  fail_single_chk: assert property (@(posedge clk) disable iff (!rstN) fail |=> !fail);

  // R1
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN) (done || fail) |=> !busy);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!flWe && !vrReq && !pulseGo && !sweOn && !pvOn));

  // R4
  read_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    vrReq |-> (pvOn && !vrAddr[0]));

  // R4
  dummy_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flWe && pvOn) |-> (flData == 8'hFF));

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN) pulseGo |=> !pulseGo);

  // R3
  pulse_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseGo |-> (sweOn && !pvOn));

endmodule

bind flash_page_prog fpv_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .fail(fail),
  .sweOn(sweOn), .pvOn(pvOn), .flWe(flWe), .flData(flData),
  .vrReq(vrReq), .vrAddr(vrAddr), .pulseGo(pulseGo)
);

// File: tb/flash_page_prog_test.sv
`timescale 1ns/1ps
module flash_page_prog_test;

  localparam int PB     = 128;
  localparam int PW     = 4;
  localparam int IW     = 7;
  localparam int AW     = PW + IW;
  localparam int LIMIT  = 10;
  localparam int EARLY  = 6;
  localparam int W_SWE  = 20;
  localparam int WD_MAX = 150000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ldEn = 1'b0;
  logic [IW-1:0] ldIdx = '0;
  logic [7:0]    ldData = '0;
  logic          start = 1'b0;
  logic [PW-1:0] pageSel = '0;
  logic          busy, done, fail, sweOn, pvOn, flWe, vrReq, pulseGo;
  logic [AW-1:0] flAddr, vrAddr;
  logic [7:0]    flData;
  logic [15:0]   vrData = '0;
  logic          vrValid = 1'b0;
  logic [1:0]    pulseSel;
  logic          pulseDone = 1'b0;

  flash_page_prog #(
    .PAGE_BYTES(PB), .PAGE_W(PW), .ITER_LIMIT(LIMIT), .EARLY_LAST(EARLY),
    .TM_W(8), .WAIT_SWE(W_SWE), .WAIT_GAMMA(4), .WAIT_EPS(2),
    .WAIT_ETA(3), .WAIT_THETA(5)
  ) uut (.*);

  always #4 clk = ~clk;   // 125 MHz

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- flash array model ----------------
  logic [7:0] expD  [PB];
  logic [7:0] latch [PB];
  logic [7:0] prevX [PB];
  int cnt  [PB][8];
  int need [PB][8];
  int normN, extraN, wrCount, pageErr, pdCnt, vrWait;
  int cyc = 0, sweRise, firstWe;
  bit sweSeen;
  logic [PW-1:0] expPage;

  function automatic logic [7:0] cellByte(input int i);
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[b] = (cnt[i][b] >= need[i][b]) ? 1'b0 : 1'b1;
    return v;
  endfunction

  task automatic applyPulse();
    int mism = 0;
    if (pulseSel == 2'd2) begin
      extraN++;
      for (int i = 0; i < PB; i++)
        if (latch[i] != (prevX[i] | cellByte(i))) mism++;
      check(mism == 0, "R6 additional bytes", mism, 0);
    end else begin
      normN++;
      check(int'(pulseSel) == ((normN <= EARLY) ? 0 : 1), "R3 pulse width code",
            int'(pulseSel), (normN <= EARLY) ? 0 : 1);
      for (int i = 0; i < PB; i++)
        if (latch[i] != (expD[i] | ~cellByte(i))) mism++;
      check(mism == 0, "R5 reprogram bytes", mism, 0);
      for (int i = 0; i < PB; i++) begin
        prevX[i] = latch[i];
        for (int b = 0; b < 8; b++) if (!latch[i][b]) cnt[i][b]++;
      end
    end
    pdCnt = 3;
  endtask

  always @(negedge clk) begin
    cyc++;
    pulseDone = 1'b0;
    vrValid   = 1'b0;
    if (sweOn && !sweSeen) begin sweSeen = 1; sweRise = cyc; end
    if (flWe) begin
      if (firstWe < 0) firstWe = cyc;
      wrCount++;
      if (flAddr[AW-1:IW] != expPage) pageErr++;
      latch[flAddr[IW-1:0]] = flData;
    end
    if (pulseGo) applyPulse();
    else if (pdCnt > 0) begin
      pdCnt--;
      if (pdCnt == 0) pulseDone = 1'b1;
    end
    if (vrReq) begin
      vrWait++;
      if (vrWait == 3) begin
        vrWait  = 0;
        vrValid = 1'b1;
        vrData  = {cellByte(int'(vrAddr[IW-1:0])), cellByte(int'(vrAddr[IW-1:0]) + 1)};
      end
    end
    if (cyc == WD_MAX) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- scenario helpers ----------------
  task automatic loadByte(input int i, input logic [7:0] d);
    @(negedge clk);
    ldEn = 1'b1; ldIdx = IW'(i); ldData = d;
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  task automatic runPage(input string name, input int page, input int loadCount, input bit meddle);
    int maxK = 0, passes, extraExp;
    bit expFail;
    bit gotDone, gotFail;
    int bad = 0;
    for (int i = 0; i < loadCount; i++) loadByte(i, expD[i]);
    for (int i = 0; i < PB; i++)
      for (int b = 0; b < 8; b++)
        if (!expD[i][b] && need[i][b] > maxK) maxK = need[i][b];
    passes  = (maxK <= EARLY) ? maxK + 1 : maxK;
    expFail = passes > LIMIT - 1;
    if (expFail) passes = LIMIT - 1;
    extraExp = (passes < EARLY) ? passes : EARLY;
    for (int i = 0; i < PB; i++) begin
      latch[i] = 8'hFF;
      for (int b = 0; b < 8; b++) cnt[i][b] = 0;
    end
    normN = 0; extraN = 0; wrCount = 0; pageErr = 0; pdCnt = 0; vrWait = 0;
    sweSeen = 0; firstWe = -1; expPage = PW'(page);
    @(negedge clk);
    pageSel = PW'(page); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (meddle) begin
      repeat (60) @(negedge clk);
      // R9: load while busy; R1: restart and new page while busy
      ldEn = 1'b1; ldIdx = 7'd40; ldData = 8'h00;
      start = 1'b1; pageSel = PW'(page + 2);
      @(negedge clk);
      ldEn = 1'b0; start = 1'b0;
    end
    while (!(done || fail)) @(negedge clk);
    gotDone = done; gotFail = fail;
    @(negedge clk);
    check(!busy && !done && !fail, {name, " R1 busy low after end"}, busy, 0);
    check(gotDone == !expFail, {name, " R7 done outcome"}, gotDone, !expFail);
    check(gotFail == expFail, {name, " R8 fail outcome"}, gotFail, expFail);
    check(normN == passes, {name, " R8 pass count"}, normN, passes);
    check(extraN == extraExp, {name, " R6 additional pulse count"}, extraN, extraExp);
    check(wrCount == passes * (PB + PB / 2) + extraExp * PB, {name, " R4 write count"},
          wrCount, passes * (PB + PB / 2) + extraExp * PB);
    check(firstWe - sweRise >= W_SWE, {name, " R1 enable settle"}, firstWe - sweRise, W_SWE);
    check(pageErr == 0, {name, " R2 page address"}, pageErr, 0);
    if (!expFail) begin
      for (int i = 0; i < PB; i++) if (cellByte(i) != expD[i]) bad++;
      check(bad == 0, {name, " R7 final contents"}, bad, 0);
    end
    repeat (5) @(negedge clk);
    if (meddle) begin
      // R1: restart while busy must not have begun a second operation
      check(!busy && !sweOn, {name, " R1 restart ignored"}, busy, 0);
    end
  endtask

  task automatic testReset();
    check(!busy && !done && !fail && !sweOn && !pvOn && !flWe && !pulseGo && !vrReq,
          "R1 reset state", busy, 0);
  endtask

  task automatic testBlank();
    for (int i = 0; i < PB; i++) begin
      expD[i] = 8'hFF;
      for (int b = 0; b < 8; b++) need[i][b] = 1;
    end
    runPage("blank", 1, 0, 1'b0);
  endtask

  task automatic testQuick();
    for (int i = 0; i < PB; i++) begin
      expD[i] = 8'(i) ^ 8'h5A;
      for (int b = 0; b < 8; b++) need[i][b] = 1;
    end
    runPage("quick", 2, PB, 1'b0);
  endtask

  task automatic testSlowPartial();
    for (int i = 0; i < PB; i++) begin
      expD[i] = (i < 16) ? (8'(i * 17) ^ 8'hC3) : 8'hFF;   // R2: rest stays 0xFF
      for (int b = 0; b < 8; b++) need[i][b] = 1 + ((i * 3 + b) % 8);
    end
    runPage("slow", 3, 16, 1'b1);
  endtask

  task automatic testBoundary();
    for (int i = 0; i < PB; i++) begin
      expD[i] = 8'h00;
      for (int b = 0; b < 8; b++) need[i][b] = 1 + ((i + b) % EARLY);
    end
    runPage("edge", 4, PB, 1'b0);
  endtask

  task automatic testExhaust();
    for (int i = 0; i < PB; i++) begin
      expD[i] = 8'hF0;
      for (int b = 0; b < 8; b++) need[i][b] = 2;
    end
    need[5][0] = 20;
    runPage("exhaust", 5, PB, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBlank();
    testQuick();
    testSlowPartial();
    testBoundary();
    testExhaust();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule